// File: doc/BRIEF.md
# Serial Receiver with Per-Entry Error Status and Hardware Flow Control

This block turns an asynchronous serial line into parallel bytes. A reference enable pulsing at sixteen times the bit rate, made by a divisor stage outside the block, paces the sampling. A falling edge on the line starts a candidate frame. The frame is confirmed half a bit later and then sampled at the middle of each bit. Every received character is stored together with its own parity, framing and break flags, so software always sees the status that belongs to the byte it reads.

After reset the receiver keeps a single character. When a configuration input turns on buffered mode, it queues up to sixteen characters. Automatic flow control can then throttle the request-to-send output from the buffer fill level. It lowers the output before the queue can overflow and raises it again once software has drained the queue well below the limit. The CPU side pops entries one at a time. A level output serves a DMA engine, and a gated data-available line serves an interrupt controller.

Top module: `uart_rx_autorts`

## Requirements
- R1: After reset the buffer is empty: `rxrdy`, `irq_rx` and `overrun` are 0.
- R2: A low pulse on `rxd` that has ended by the 8th reference tick after its falling edge is discarded and stores nothing.
- R3: The frame is a low start bit, then 8 data bits least significant bit first, then an optional parity bit, then one stop bit. Each bit is sampled at its mid-point, and the byte appears on `rd_data`.
- R4: With `parity_en`=1, the parity bit is expected to make the count of ones even (`parity_odd`=0) or odd (`parity_odd`=1). A mismatch sets `rd_err[0]` for that entry only. With `parity_en`=0, no parity bit is present and `rd_err[0]` is 0.
- R5: A stop bit sampled low sets `rd_err[1]` (framing) for that entry.
- R6: A character whose data bits are all 0, whose parity bit (if present) is 0 and whose stop bit is low sets `rd_err[2]` (break) as well as `rd_err[1]`. The receiver then waits for the line to return high before it looks for a new start bit.
- R7: With `fifo_en`=0, one entry is held. A character that completes while that entry is unread is dropped, the held entry is kept, and `overrun` is set.
- R8: With `fifo_en`=1, up to 16 entries are returned in arrival order. A 17th character is dropped and sets `overrun`. Fullness is judged before any pop in the same cycle.
- R9: `overrun` stays set until a `stat_rd` pulse clears it. A drop in the same cycle as the pulse wins.
- R10: With `fifo_en`=1 and `autoflow_en`=1, `rts` goes to 0 once 14 entries are held and returns to 1 once 8 or fewer remain.
- R11: When `fifo_en` or `autoflow_en` is 0, `rts` equals `rts_sw`.
- R12: `rxrdy` is 1 exactly while at least one entry is held, and `irq_rx` is `rxrdy` gated by `irq_en`.
- R13: Any change of `fifo_en` empties the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x bit rate |
| rxd | input | 1 | Serial input, idle high |
| fifo_en | input | 1 | 1 = sixteen-entry buffered mode |
| autoflow_en | input | 1 | 1 = hardware RTS throttling (buffered mode only) |
| rts_sw | input | 1 | Software RTS level |
| parity_en | input | 1 | 1 = frame carries a parity bit |
| parity_odd | input | 1 | 1 = odd parity, 0 = even |
| irq_en | input | 1 | Data-available interrupt enable |
| rd_pop | input | 1 | Remove the head entry |
| stat_rd | input | 1 | Status read, clears overrun |
| rd_data | output | 8 | Head entry data byte |
| rd_err | output | 3 | Head entry flags: [2] break, [1] framing, [0] parity |
| rxrdy | output | 1 | Data available (DMA request level) |
| irq_rx | output | 1 | Data-available interrupt |
| overrun | output | 1 | Sticky character-lost flag |
| rts | output | 1 | Request to send, active high |

## Verification
Random bytes are sent in both parity senses and with no parity, with wrong parity bits and low stop bits injected at random. These frames separate the bit-ordering path from the per-entry flag path, and they show whether flags leak between neighbouring entries. Directed patterns cover the rest. A short low glitch tests start qualification. A long low line tests break handling and the wait for the line to go high. Two unread characters in single mode test dropping. A fill to seventeen entries followed by a drain walks through both RTS thresholds and the overflow point. Mode toggles show the flush and the fallback to software RTS.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic       brk;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rx_entry_t;

  // value the parity bit must carry
  function automatic logic parity_expect(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  function automatic logic is_break(input logic [7:0] d, input logic par_en,
                                    input logic par_bit, input logic stop_bit);
    return (d == 8'h00) && !stop_bit && (!par_en || !par_bit);
  endfunction
endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick16,
  input  logic      rxd_s,
  input  logic      parity_en,
  input  logic      parity_odd,
  output logic      done,
  output rx_entry_t entry
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;
  st_t        st;
  logic [3:0] cnt;
  logic [2:0] bitn;
  logic [7:0] shreg;
  logic       par_bit;

  wire mid_tick   = tick16 && (cnt == 4'd15);
  wire start_ok   = tick16 && (st == S_START) && (cnt == 4'd7) && !rxd_s;
  wire stop_event = mid_tick && (st == S_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; shreg <= '0; par_bit <= 1'b0;
      done <= 1'b0; entry <= '0;
    end else begin
      done <= 1'b0;
      if (tick16) begin
        unique case (st)
          S_IDLE: if (!rxd_s) begin st <= S_START; cnt <= '0; end
          S_START: begin
            if (cnt == 4'd7) begin
              cnt <= '0; bitn <= '0; par_bit <= 1'b0;
              st  <= start_ok ? S_DATA : S_IDLE;
            end else cnt <= cnt + 4'd1;
          end
          S_DATA: begin
            cnt <= cnt + 4'd1;
            if (mid_tick) begin
              shreg <= {rxd_s, shreg[7:1]};
              bitn  <= bitn + 3'd1;
              if (bitn == 3'd7) st <= parity_en ? S_PAR : S_STOP;
            end
          end
          S_PAR: begin
            cnt <= cnt + 4'd1;
            if (mid_tick) begin par_bit <= rxd_s; st <= S_STOP; end
          end
          S_STOP: begin
            cnt <= cnt + 4'd1;
            if (stop_event) begin
              done       <= 1'b1;
              entry.data <= shreg;
              entry.pe   <= parity_en && (par_bit != parity_expect(shreg, parity_odd));
              entry.fe   <= !rxd_s;
              entry.brk  <= is_break(shreg, parity_en, par_bit, rxd_s);
              st         <= rxd_s ? S_IDLE : S_HOLD;
            end
          end
          S_HOLD: if (rxd_s) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_brk_has_fe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && entry.brk) |-> entry.fe);
  p_hold_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && !rxd_s) |=> (st == S_HOLD));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          push,
  input  rx_entry_t     wr_entry,
  input  logic          pop,
  input  logic          stat_rd,
  output rx_entry_t     head,
  output logic [CW-1:0] count,
  output logic          ovr
);
  rx_entry_t       mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic            mode_q;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  wire [CW-1:0] cap    = fifo_en ? CW'(DEPTH) : CW'(1);
  wire          full   = (count >= cap);
  wire          flush  = (fifo_en != mode_q);
  wire          accept = push && !full && !flush;
  wire          drop   = push && full;
  wire          take   = pop && (count != '0) && !flush;

  assign head = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; mode_q <= 1'b0; ovr <= 1'b0;
    end else begin
      mode_q <= fifo_en;
      if (flush) begin
        wp <= '0; rp <= '0; count <= '0;
      end else begin
        if (accept) wp <= ptr_next(wp);
        if (take)   rp <= ptr_next(rp);
        count <= count + CW'(accept) - CW'(take);
      end
      if (drop) ovr <= 1'b1;
      else if (stat_rd) ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk) if (accept) mem[wp] <= wr_entry;

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_single_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !mode_q) |-> count <= CW'(1));
  p_drop_sets_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovr);
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !stat_rd) |=> ovr);
  p_flush_empties_r13: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
endmodule

// File: rtl/uart_rx_flow.sv
module uart_rx_flow #(
  parameter int DEPTH   = 16,
  parameter int THR_OFF = 14,
  parameter int THR_ON  = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_on,
  input  logic          rts_sw,
  input  logic [CW-1:0] count,
  output logic          rts
);
  logic hold_off;
  wire  hit_high = (count >= CW'(THR_OFF));
  wire  hit_low  = (count <= CW'(THR_ON));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_off <= 1'b0;
    else if (!auto_on) hold_off <= 1'b0;
    else if (hit_high) hold_off <= 1'b1;
    else if (hit_low) hold_off <= 1'b0;
  end

  assign rts = auto_on ? !hold_off : rts_sw;

  p_rts_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_on && hit_high) |=> (!rts || !auto_on));
  p_rts_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_on && hit_low) |=> (rts || !auto_on || hit_high));
endmodule

// File: rtl/uart_rx_autorts.sv
module uart_rx_autorts
  import uart_rx_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int THR_OFF = 14,
  parameter int THR_ON  = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       fifo_en,
  input  logic       autoflow_en,
  input  logic       rts_sw,
  input  logic       parity_en,
  input  logic       parity_odd,
  input  logic       irq_en,
  input  logic       rd_pop,
  input  logic       stat_rd,
  output logic [7:0] rd_data,
  output logic [2:0] rd_err,
  output logic       rxrdy,
  output logic       irq_rx,
  output logic       overrun,
  output logic       rts
);
  logic [1:0]    sync_q;
  logic          frame_done;
  rx_entry_t     frame_entry, head;
  logic [CW-1:0] level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  uart_rx_frame u_frame (
    .clk, .rst_n, .tick16, .rxd_s(sync_q[1]), .parity_en, .parity_odd,
    .done(frame_done), .entry(frame_entry)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk, .rst_n, .fifo_en, .push(frame_done), .wr_entry(frame_entry),
    .pop(rd_pop), .stat_rd, .head, .count(level), .ovr(overrun)
  );

  uart_rx_flow #(.DEPTH(DEPTH), .THR_OFF(THR_OFF), .THR_ON(THR_ON)) u_flow (
    .clk, .rst_n, .auto_on(fifo_en && autoflow_en), .rts_sw, .count(level), .rts
  );

  assign rd_data = head.data;
  assign rd_err  = {head.brk, head.fe, head.pe};
  assign rxrdy   = (level != '0);
  assign irq_rx  = irq_en && rxrdy;

  p_irq_needs_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> (rxrdy && irq_en));
endmodule

// File: tb/uart_rx_autorts_tb_top.sv
module uart_rx_autorts_tb_top;
  logic clk = 0, rst_n = 0, tick16 = 0, rxd = 1;
  logic fifo_en = 0, autoflow_en = 0, rts_sw = 1, parity_en = 0, parity_odd = 0;
  logic irq_en = 0, rd_pop = 0, stat_rd = 0;
  logic [7:0] rd_data; logic [2:0] rd_err;
  logic rxrdy, irq_rx, overrun, rts;
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [1:0] tdiv = 0;
  logic done_flag = 0;

  uart_rx_autorts dut_i (.*);

  always #5 clk = ~clk;
  always @(negedge clk) begin tdiv <= tdiv + 2'd1; tick16 <= (tdiv == 2'd2); end

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin n_chk++; n_bad++; $display("FAIL watchdog: act=hung exp=done"); summary(); end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin n_bad++; $display("FAIL %s: act=%0h exp=%0h", req, act, exp); end
  endtask

  function automatic logic par_bit(logic [7:0] d, logic odd);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    return ((ones % 2) == 1) ? !odd : odd;
  endfunction

  function automatic logic [2:0] exp_err(logic [7:0] d, logic pen, logic bad_par, logic bad_stop, logic odd);
    logic pb = par_bit(d, odd) ^ bad_par;
    logic b  = bad_stop && d == 0 && (!pen || !pb);
    return {b, bad_stop, pen && bad_par};
  endfunction

  task automatic bit_time(logic v); rxd = v; repeat (64) @(negedge clk); endtask

  task automatic send(logic [7:0] d, logic bad_par = 0, logic bad_stop = 0);
    bit_time(0);
    for (int i = 0; i < 8; i++) bit_time(d[i]);
    if (parity_en) bit_time(par_bit(d, parity_odd) ^ bad_par);
    bit_time(!bad_stop);
    bit_time(1);
  endtask

  task automatic pop_chk(string req, logic [7:0] d, logic [2:0] e);
    chk({req, " rxrdy"}, rxrdy, 1);
    chk({req, " data"}, rd_data, d);
    chk({req, " err"}, rd_err, e);
    rd_pop = 1; @(negedge clk); rd_pop = 0; @(negedge clk);
  endtask

  task automatic status_read(); stat_rd = 1; @(negedge clk); stat_rd = 0; @(negedge clk); endtask

  initial begin
    logic [7:0] d; logic bp, bs;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    // R1 reset state
    chk("R1 rxrdy", rxrdy, 0); chk("R1 irq", irq_rx, 0); chk("R1 ovr", overrun, 0);
    // R11 software RTS in single mode
    autoflow_en = 1; rts_sw = 0; @(negedge clk); chk("R11 rts low", rts, 0);
    rts_sw = 1; @(negedge clk); chk("R11 rts high", rts, 1);
    // R2 glitch
    rxd = 0; repeat (16) @(negedge clk); rxd = 1; repeat (256) @(negedge clk);
    chk("R2 glitch ignored", rxrdy, 0);
    // R3/R12 single char
    irq_en = 1; send(8'hA5); chk("R12 irq", irq_rx, 1);
    pop_chk("R3", 8'hA5, 3'b000); chk("R12 empty", rxrdy, 0);
    irq_en = 0; send(8'h3C); chk("R12 irq gated", irq_rx, 0); pop_chk("R3", 8'h3C, 3'b000);
    // R7 single-mode overrun
    send(8'h11); send(8'h22); chk("R7 ovr", overrun, 1);
    pop_chk("R7 kept first", 8'h11, 3'b000); chk("R7 only one", rxrdy, 0);
    status_read(); chk("R9 ovr cleared", overrun, 0);
    // R6 break: line low ~12 bits
    rxd = 0; repeat (12 * 64) @(negedge clk); rxd = 1; repeat (192) @(negedge clk);
    pop_chk("R6 break", 8'h00, 3'b110); chk("R6 single entry", rxrdy, 0);
    // R5 framing on nonzero byte
    send(8'h81, 0, 1); pop_chk("R5", 8'h81, 3'b010);
    // random frames: R3 R4 R5 in FIFO mode
    fifo_en = 1; autoflow_en = 0; @(negedge clk); @(negedge clk);
    for (int k = 0; k < 24; k++) begin
      if (k % 8 == 0) begin
        parity_en = (k != 16); parity_odd = (k == 8); @(negedge clk);
      end
      d = 8'($urandom); bp = ($urandom % 4) == 0; bs = ($urandom % 5) == 0;
      send(d, bp, bs);
      pop_chk("R4 random", d, exp_err(d, parity_en, bp, bs, parity_odd));
    end
    parity_en = 0;
    // R13 flush
    send(8'h55); send(8'h66); fifo_en = 0; @(negedge clk); @(negedge clk);
    chk("R13 flushed", rxrdy, 0);
    fifo_en = 1; @(negedge clk); @(negedge clk);
    // R8/R10 fill
    autoflow_en = 1; @(negedge clk); chk("R10 rts idle", rts, 1);
    for (int k = 0; k < 13; k++) send(8'(k + 8'h40));
    chk("R10 13 held", rts, 1);
    send(8'h4D); chk("R10 14 held", rts, 0);
    send(8'h4E); send(8'h4F); chk("R8 no ovr at 16", overrun, 0);
    send(8'hEE); chk("R8 ovr at 17", overrun, 1);
    status_read();
    for (int k = 0; k < 8; k++) pop_chk("R8 order", 8'(k + 8'h40), 3'b000);
    chk("R10 still low at 8 popped? count 8", rts, 1);
    fifo_en = 1; // remain
    for (int k = 8; k < 16; k++) pop_chk("R8 order", 8'(k + 8'h40), 3'b000);
    chk("R8 drained", rxrdy, 0);
    // R10 hysteresis: fill 14, pop to 9 stays low
    for (int k = 0; k < 14; k++) send(8'(k));
    chk("R10 low", rts, 0);
    for (int k = 0; k < 5; k++) pop_chk("R10 drain", 8'(k), 3'b000);
    chk("R10 low at 9", rts, 0);
    pop_chk("R10 drain", 8'd5, 3'b000); chk("R10 high at 8", rts, 1);
    // R11 autoflow off -> software
    autoflow_en = 0; rts_sw = 0; @(negedge clk); chk("R11 sw", rts, 0);
    summary();
  end
endmodule